// File: doc/BRIEF.md
# Addressable LED Bit Encoder

This block turns one 24-bit colour word into the single-wire pulse train that a chain-type RGB LED such as the WS2812B reads. A counter divides the system clock down to a sub-period enable. Every colour bit then takes exactly four sub-periods on the line. The first sub-period is always high and the last is always low. The two middle sub-periods copy the bit value. A one is therefore seen as a long high pulse and a zero as a short one.

A client places red, green and blue on the colour inputs and raises `valid`. The block accepts the request only while it is idle. In the cycle of acceptance it captures the colour word, raises `busy` and drives the line high. It lowers `busy` once the low phase of the last bit is finished. A parameter sets the order in which the three bytes leave. The whole block runs on the system clock, and the divider produces an enable pulse instead of a second clock.

Spacing frames apart and addressing several pixels are the job of the logic around the block.

Top module: `pixel_bit_encoder`

## Requirements
- R1: While reset is asserted and after reset is released, `dout` and `busy` are both low.
- R2: When `valid` is high and `busy` is low at a rising clock edge, `busy` and `dout` both go high at that same edge.
- R3: Each bit occupies four consecutive phases of DIV = CLK_HZ/SUB_HZ clock cycles each. Phase 1 is driven high and phase 4 is driven low.
- R4: Phases 2 and 3 of a bit carry the bit value. A one is therefore high for 3·DIV cycles and a zero for DIV cycles, and each is followed by the low phase.
- R5: With the default ORDER (`ORD_GRB`), the word sent is {green, red, blue}, 24 bits with bit 23 first, which is the most significant bit of green.
- R6: With ORDER set to `ORD_RGB`, the word sent is {red, green, blue}, with the most significant bit of red first.
- R7: `busy` stays high for exactly 96·DIV cycles from the accepting edge and then falls. While `busy` is low, `dout` is low.
- R8: While `busy` is high, changes on `valid`, `red`, `green` and `blue` have no effect on the frame in progress.
- R9: If `valid` is held high, the next frame is accepted one cycle after `busy` falls, so the line is idle and low for exactly one cycle between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| valid | input | 1 | Request to send the colour on the inputs |
| red | input | CH_W | Red intensity |
| green | input | CH_W | Green intensity |
| blue | input | CH_W | Blue intensity |
| busy | output | 1 | High from acceptance until the last bit ends |
| dout | output | 1 | Registered serial line to the LED |

## Verification
The assertions take for granted that CLK_HZ is at least SUB_HZ, so that DIV is one or more. They also assume that `rst_n` is released away from a clock edge, and that the internal sub-period enable fires only while a frame is in progress. The stimulus runs with DIV set to 3, so that an error of one cycle in the divider shows up. It lowers and raises `valid` only at falling edges, and each colour request is timed either at idle or deliberately in the middle of a frame. Frames with `valid` held high across the end of a frame exercise the single idle cycle between frames.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;
  typedef enum logic [2:0] {
    ORD_GRB,
    ORD_RGB,
    ORD_BRG,
    ORD_BGR,
    ORD_RBG,
    ORD_GBR
  } ord_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_DATA_A,
    ST_DATA_B,
    ST_TAIL
  } phase_e;
endpackage

// File: rtl/led_word_pack.sv
module led_word_pack #(
  parameter int               CH_W  = 8,
  parameter led_enc_pkg::ord_e ORDER = led_enc_pkg::ORD_GRB
) (
  input  logic [CH_W-1:0]   red,
  input  logic [CH_W-1:0]   green,
  input  logic [CH_W-1:0]   blue,
  output logic [3*CH_W-1:0] word
);
  generate
    if (ORDER == led_enc_pkg::ORD_RGB) begin : g_rgb
      assign word = {red, green, blue};
    end else if (ORDER == led_enc_pkg::ORD_BRG) begin : g_brg
      assign word = {blue, red, green};
    end else if (ORDER == led_enc_pkg::ORD_BGR) begin : g_bgr
      assign word = {blue, green, red};
    end else if (ORDER == led_enc_pkg::ORD_RBG) begin : g_rbg
      assign word = {red, blue, green};
    end else if (ORDER == led_enc_pkg::ORD_GBR) begin : g_gbr
      assign word = {green, blue, red};
    end else begin : g_grb
      assign word = {green, red, blue};
    end
  endgenerate
endmodule

// File: rtl/led_tick_div.sv
module led_tick_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNTW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(DIV - 1);

  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] cnt_d;

  always_comb begin
    tick  = run && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (!run || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/led_bit_fsm.sv
module led_bit_fsm #(
  parameter int NBITS = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [NBITS-1:0] word,
  output logic             busy,
  output logic             dout
);
  import led_enc_pkg::*;

  localparam int BCW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(NBITS - 1);

  phase_e           st_q, st_d;
  logic [NBITS-1:0] sh_q, sh_d;
  logic [BCW-1:0]   bc_q, bc_d;
  logic             dout_q, dout_d;
  logic             load_en;

  assign load_en = (st_q == ST_IDLE) || tick;

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    bc_d   = bc_q;
    dout_d = dout_q;
    case (st_q)
      ST_IDLE: begin
        dout_d = 1'b0;
        if (start) begin
          st_d   = ST_LEAD;
          sh_d   = word;
          bc_d   = '0;
          dout_d = 1'b1;
        end
      end
      ST_LEAD: begin
        st_d   = ST_DATA_A;
        dout_d = sh_q[NBITS-1];
      end
      ST_DATA_A: begin
        st_d   = ST_DATA_B;
        dout_d = sh_q[NBITS-1];
      end
      ST_DATA_B: begin
        st_d   = ST_TAIL;
        dout_d = 1'b0;
      end
      ST_TAIL: begin
        if (bc_q == LAST_BIT) begin
          st_d   = ST_IDLE;
          dout_d = 1'b0;
        end else begin
          st_d   = ST_LEAD;
          dout_d = 1'b1;
          sh_d   = {sh_q[NBITS-2:0], 1'b0};
          bc_d   = bc_q + 1'b1;
        end
      end
      default: begin
        st_d   = ST_IDLE;
        dout_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      bc_q   <= '0;
      dout_q <= 1'b0;
    end else if (load_en) begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      bc_q   <= bc_d;
      dout_q <= dout_d;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign dout = dout_q;
endmodule

// File: rtl/pixel_bit_encoder.sv
module pixel_bit_encoder #(
  parameter int                CLK_HZ = 12_000_000,
  parameter int                SUB_HZ = 2_500_000,
  parameter int                CH_W   = 8,
  parameter led_enc_pkg::ord_e ORDER  = led_enc_pkg::ORD_GRB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic [CH_W-1:0] red,
  input  logic [CH_W-1:0] green,
  input  logic [CH_W-1:0] blue,
  output logic            busy,
  output logic            dout
);
  localparam int DIV   = (CLK_HZ / SUB_HZ > 0) ? (CLK_HZ / SUB_HZ) : 1;
  localparam int NBITS = 3 * CH_W;

  logic [NBITS-1:0] colour_word;
  logic             sub_tick;
  logic             busy_w;

  led_word_pack #(.CH_W(CH_W), .ORDER(ORDER)) u_pack (
    .red   (red),
    .green (green),
    .blue  (blue),
    .word  (colour_word)
  );

  led_tick_div #(.DIV(DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy_w),
    .tick  (sub_tick)
  );

  led_bit_fsm #(.NBITS(NBITS)) u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (sub_tick),
    .start (valid),
    .word  (colour_word),
    .busy  (busy_w),
    .dout  (dout)
  );

  assign busy = busy_w;
endmodule

// File: rtl/pixel_bit_encoder_chk.sv
module pixel_bit_encoder_chk #(
  parameter int DIV   = 4,
  parameter int NBITS = 24
) (
  input logic clk,
  input logic rst_n,
  input logic valid,
  input logic busy,
  input logic dout,
  input logic tick
);
  int gap_q;
  int ticks_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= 0;
      ticks_q <= 0;
    end else begin
      if (!busy || tick) gap_q <= 0;
      else               gap_q <= gap_q + 1;
      if (!busy)         ticks_q <= 0;
      else if (tick)     ticks_q <= ticks_q + 1;
    end
  end

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dout);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !busy) |=> (busy && dout));

  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q == DIV - 1));

  p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(dout));

  p_frame_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (ticks_q == 4 * NBITS));

  p_end_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick));
endmodule

bind pixel_bit_encoder pixel_bit_encoder_chk #(.DIV(DIV), .NBITS(NBITS)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .valid (valid),
  .busy  (busy),
  .dout  (dout),
  .tick  (sub_tick)
);

// File: tb/pixel_bit_encoder_tb_top.sv
`timescale 1ns/1ps
module pixel_bit_encoder_tb_top;
  localparam int DIV = 3;
  localparam int NB  = 24;
  localparam int FRAME = NB * 4 * DIV;

  logic clk;
  logic rst_n;
  logic valid;
  logic [7:0] red, green, blue;
  logic busy_a, dout_a, busy_b, dout_b;
  int   n_chk;
  int   n_fail;
  bit   done;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  pixel_bit_encoder #(.CLK_HZ(30), .SUB_HZ(10), .CH_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .valid(valid), .red(red), .green(green),
    .blue(blue), .busy(busy_a), .dout(dout_a)
  );

  pixel_bit_encoder #(.CLK_HZ(30), .SUB_HZ(10), .CH_W(8),
                      .ORDER(led_enc_pkg::ORD_RGB)) dut_rgb_i (
    .clk(clk), .rst_n(rst_n), .valid(valid), .red(red), .green(green),
    .blue(blue), .busy(busy_b), .dout(dout_b)
  );

  function automatic logic exp_bit(logic [NB-1:0] w, int k);
    int b;
    int p;
    b = k / (4 * DIV);
    p = (k / DIV) % 4;
    if (p == 0) return 1'b1;
    if (p == 3) return 1'b0;
    return w[NB-1-b];
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // mode 0: single request, 1: noise on inputs mid-frame, 2: keep valid high
  task automatic send(logic [7:0] r, logic [7:0] g, logic [7:0] b, int mode);
    logic [NB-1:0] wg;
    logic [NB-1:0] wr;
    string tg;
    wg = {g, r, b};
    wr = {r, g, b};
    red = r; green = g; blue = b;
    valid = 1'b1;
    for (int k = 0; k < FRAME; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 0 && mode != 2) valid = 1'b0;
      if (mode == 1 && k == 7) begin
        valid = 1'b1;
        red = 8'($urandom); green = 8'($urandom); blue = 8'($urandom);
      end
      if (mode == 1 && k == FRAME - 4) valid = 1'b0;
      if (k == 0) chk(busy_a == 1'b1 && dout_a == 1'b1, "R2 accept", int'(busy_a), 1);
      if (mode == 1)                      tg = "R8 ignored input";
      else if (((k / DIV) % 4) == 0)      tg = "R3 lead phase";
      else if (((k / DIV) % 4) == 3)      tg = "R3 tail phase";
      else if (mode == 2)                 tg = "R9 data phase";
      else                                tg = "R4 R5 data phase";
      chk(dout_a == exp_bit(wg, k), tg, int'(dout_a), int'(exp_bit(wg, k)));
      chk(dout_b == exp_bit(wr, k), "R6 rgb order", int'(dout_b), int'(exp_bit(wr, k)));
      chk(busy_a == 1'b1, "R7 busy during frame", int'(busy_a), 1);
    end
    @(posedge clk);
    @(negedge clk);
    chk(busy_a == 1'b0 && dout_a == 1'b0, "R7 idle after frame", int'(busy_a), 0);
    if (mode == 2) chk(busy_b == 1'b0, "R9 single idle cycle", int'(busy_b), 0);
  endtask

  initial begin
    int seed;
    n_chk = 0; n_fail = 0; done = 1'b0;
    seed = int'($urandom(32'h5EED_0042));
    rst_n = 1'b0; valid = 1'b0; red = '0; green = '0; blue = '0;
    repeat (3) @(negedge clk);
    chk(dout_a == 1'b0 && busy_a == 1'b0, "R1 in reset", int'(dout_a), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dout_a == 1'b0 && busy_a == 1'b0, "R1 after reset", int'(busy_a), 0);

    send(8'hFF, 8'hFF, 8'hFF, 0);
    send(8'h00, 8'h00, 8'h00, 0);
    send(8'h01, 8'h80, 8'h00, 0);
    send(8'hAA, 8'h55, 8'h0F, 1);
    send(8'h12, 8'h34, 8'h56, 2);
    send(8'h81, 8'h7E, 8'hC3, 0);
    for (int i = 0; i < 12; i++) begin
      send(8'($urandom), 8'($urandom), 8'($urandom), (i == 11) ? 0 : int'($urandom % 3));
    end
    repeat (5) @(negedge clk);
    chk(dout_a == 1'b0 && busy_a == 1'b0, "R7 stays idle", int'(dout_a), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule